// File: doc/BRIEF.md
# Multiplexed Gate Blanking Generator

This block turns one gate command per power-switch channel into a complementary pair of drive signals, an upper and a lower gate. After every transition of the command it inserts a blanking interval during which both drives are off. A single compare datapath serves all channels in turn. A slot counter visits channel 0, 1, ... N-1 and then wraps. On each visit the block samples that channel's command, updates a small per-channel state record, and refreshes that channel's two output registers.

The blanking length is a run-time input counted in multiplexing frames. One frame lasts N clocks, so the interval is setting × N × clock period. With the default 4 channels, a 16-bit setting and a 5 ns clock, the longest interval is about 1.3 ms. Each channel keeps the last command level it saw and a saturating count of frames since that level last changed. A drive is enabled only when the command calls for it and the count has reached the setting. The setting is latched once per frame, so a change made mid-frame never splits a frame between two values.

Top module: `gate_blank_mux`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, both drive buses go to all zeros, the slot counter returns to 0, every channel's stored level becomes 0 with its frame count saturated, and the latched blanking setting becomes 0.
- R2: When channel k is visited, `hi_gate[k]` becomes 1 exactly when the sampled command is 1 and the updated frame count is at least the latched setting. `lo_gate[k]` becomes 1 exactly when the command is 0 and the same count condition holds.
- R3: No channel ever has `hi_gate` and `lo_gate` high together.
- R4: With a latched setting of 0, a visited channel gets `hi_gate[k]` equal to its command and `lo_gate[k]` equal to its inverse.
- R5: When a command rises, `lo_gate[k]` falls at the edge of the visit that sees the rise. `hi_gate[k]` rises exactly setting × N clocks after that edge.
- R6: When a command falls, `hi_gate[k]` falls at the edge of the visit that sees the fall. `lo_gate[k]` rises exactly setting × N clocks after that edge.
- R7: `blank_frames` is captured only at the edge that serves slot N-1. The new value first applies to slot 0 of the following frame, and channels still pending in the current frame keep the old value.
- R8: Slots are served in ascending order 0..N-1, one per clock, and the first edge after reset serves slot 0. A channel's outputs change only at the edge that serves its slot.
- R9: The per-channel frame count saturates at all ones and never wraps. A channel whose command is unchanged since reset therefore meets any setting, including 65535.
- R10: A command pulse shorter than the setting in frames never raises the opposite-side drive. The idle-side drive returns setting frames after the pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gate_cmd | input | NUM_CH | Gate command per channel, 1 = upper switch on |
| blank_frames | input | CNT_W | Blanking interval in frames of NUM_CH clocks |
| hi_gate | output | NUM_CH | Upper drive per channel |
| lo_gate | output | NUM_CH | Lower drive per channel |

## Verification
The bench measures the exact clock count from a command edge to the delayed drive on both polarities. A design that counted clocks instead of frames, or that was off by one visit, shows a different distance. It changes the setting in the middle of a frame and checks that the later slots of that frame still use the old value; a design that applied the setting at once would turn those drives on a frame early. It reloads reset with the largest setting to expose a count that wraps instead of saturating: such a count would drop the lower drives. It also feeds a pulse shorter than the blanking interval, which a design that lost the edge restart would pass through as a short upper drive.

// File: rtl/gate_blank_pkg.sv
`timescale 1ns/1ps
// Shared defaults for the multiplexed gate blanking generator.
package gate_blank_pkg;
    localparam int unsigned GB_DEF_CH    = 4;   // channels sharing one datapath
    localparam int unsigned GB_DEF_CNT_W = 16;  // width of frame counts and setting
endpackage

// File: rtl/gb_slot_seq.sv
`timescale 1ns/1ps
// Slot sequencer: walks slot 0..NUM_CH-1, one per clock, and flags the
// last slot of a frame. Assumes NUM_CH >= 1 and a synchronous active-low reset.
module gb_slot_seq #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [SLOT_W-1:0] slot_o,
    output logic              frame_end_o
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_CH - 1);

    assign frame_end_o = (slot_o == LAST);

    // advance the slot pointer, wrapping at the frame end
    always_ff @(posedge clk) begin
        if (!rst_n)           slot_o <= '0;
        else if (frame_end_o) slot_o <= '0;
        else                  slot_o <= slot_o + SLOT_W'(1);
    end

    // R8
    slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end_o |=> (slot_o == '0));
    // R8
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_o <= LAST);
endmodule

// File: rtl/gb_state_file.sv
`timescale 1ns/1ps
// Per-channel state file: one level bit and one saturating frame count per
// channel. The visited slot is read, updated from the sampled command and
// written back in the same cycle. The updated values are also returned.
// Reset leaves every count saturated so that idle channels meet any setting.
module gb_state_file #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned SLOT_W = 2,
    parameter int unsigned CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic              gate_i,
    output logic [CNT_W-1:0]  cnt_nxt_o
);
    logic             last_q [NUM_CH];
    logic [CNT_W-1:0] cnt_q  [NUM_CH];
    logic             last_rd;
    logic [CNT_W-1:0] cnt_rd;

    // read port for the visited slot
    always_comb begin
        last_rd = last_q[slot_i];
        cnt_rd  = cnt_q[slot_i];
    end

    // restart on any command edge, otherwise count up and stick at all ones
    always_comb begin
        if (gate_i != last_rd) cnt_nxt_o = '0;
        else if (&cnt_rd)      cnt_nxt_o = cnt_rd;
        else                   cnt_nxt_o = cnt_rd + CNT_W'(1);
    end

    // write back the visited slot only
    always_ff @(posedge clk) begin
        for (int k = 0; k < NUM_CH; k++) begin
            if (!rst_n) begin
                last_q[k] <= 1'b0;
                cnt_q[k]  <= '1;
            end else if (slot_i == SLOT_W'(k)) begin
                last_q[k] <= gate_i;
                cnt_q[k]  <= cnt_nxt_o;
            end
        end
    end

    // R5
    edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_i != last_rd) |=> (cnt_q[$past(slot_i)] == '0));
    // R9
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((gate_i == last_rd) && (&cnt_rd)) |=> (&cnt_q[$past(slot_i)]));
endmodule

// File: rtl/gb_blank_cmp.sv
`timescale 1ns/1ps
// Blanking compare: decides the two drives of the visited channel from its
// command and its updated frame count. Purely combinational.
module gb_blank_cmp #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             gate_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] dt_i,
    output logic             hi_o,
    output logic             lo_o
);
    logic settled;

    // a drive is allowed once the command has been steady long enough
    always_comb begin
        settled = (cnt_i >= dt_i);
        hi_o    = gate_i & settled;
        lo_o    = ~gate_i & settled;
    end
endmodule

// File: rtl/gate_blank_mux.sv
`timescale 1ns/1ps
// Multiplexed gate blanking generator. One compare path serves NUM_CH
// channels in turn. The blanking setting is counted in frames of NUM_CH
// clocks and latched at the last slot of each frame. Each channel's drive
// pair is held in output registers that refresh only on its own slot.
module gate_blank_mux
    import gate_blank_pkg::*;
#(
    parameter int unsigned NUM_CH = GB_DEF_CH,
    parameter int unsigned CNT_W  = GB_DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] gate_cmd,
    input  logic [CNT_W-1:0]  blank_frames,
    output logic [NUM_CH-1:0] hi_gate,
    output logic [NUM_CH-1:0] lo_gate
);
    localparam int unsigned SLOT_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    logic [SLOT_W-1:0] slot;
    logic              frame_end;
    logic [CNT_W-1:0]  dt_eff;
    logic              gate_cur;
    logic [CNT_W-1:0]  cnt_nxt;
    logic              hi_n;
    logic              lo_n;

    gb_slot_seq #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .slot_o(slot), .frame_end_o(frame_end));

    // latch the blanking setting once per frame
    always_ff @(posedge clk) begin
        if (!rst_n)         dt_eff <= '0;
        else if (frame_end) dt_eff <= blank_frames;
    end

    // pick the command of the visited channel
    assign gate_cur = gate_cmd[slot];

    gb_state_file #(.NUM_CH(NUM_CH), .SLOT_W(SLOT_W), .CNT_W(CNT_W)) u_state (
        .clk(clk), .rst_n(rst_n), .slot_i(slot), .gate_i(gate_cur),
        .cnt_nxt_o(cnt_nxt));

    gb_blank_cmp #(.CNT_W(CNT_W)) u_cmp (
        .gate_i(gate_cur), .cnt_i(cnt_nxt), .dt_i(dt_eff),
        .hi_o(hi_n), .lo_o(lo_n));

    // demultiplex the shared result into the visited channel's output pair
    always_ff @(posedge clk) begin
        for (int k = 0; k < NUM_CH; k++) begin
            if (!rst_n) begin
                hi_gate[k] <= 1'b0;
                lo_gate[k] <= 1'b0;
            end else if (slot == SLOT_W'(k)) begin
                hi_gate[k] <= hi_n;
                lo_gate[k] <= lo_n;
            end
        end
    end

    // R3
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_gate & lo_gate) == '0);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (hi_gate == '0 && lo_gate == '0));
    // R7
    dt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> $stable(dt_eff));
    // R4
    zero_dt_compl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dt_eff == '0) |=> (hi_gate[$past(slot)] == ~lo_gate[$past(slot)]));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_hold
        // R8
        idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (slot != SLOT_W'(g)) |=> ($stable(hi_gate[g]) && $stable(lo_gate[g])));
    end
endmodule

// File: tb/tb_gate_blank_mux.sv
`timescale 1ns/1ps
module tb_gate_blank_mux;
    localparam int NCH = 4;
    localparam int CW  = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  gate_cmd = '0;
    logic [CW-1:0]   blank_frames = '0;
    logic [NCH-1:0]  hi_gate;
    logic [NCH-1:0]  lo_gate;

    gate_blank_mux #(.NUM_CH(NCH), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .gate_cmd(gate_cmd), .blank_frames(blank_frames),
        .hi_gate(hi_gate), .lo_gate(lo_gate));

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit reported = 1'b0;

    // reference model built from the requirements
    int             m_slot = 0;
    logic [CW-1:0]  m_dt = '0;
    logic           m_last [NCH];
    logic [CW-1:0]  m_cnt  [NCH];
    logic [NCH-1:0] m_hi = '0;
    logic [NCH-1:0] m_lo = '0;

    // stimulus table: {gate[27:24], setting[23:8], frames[7:0]}
    localparam logic [27:0] VEC [8] = '{
        {4'b0101, 16'd0, 8'd2}, {4'b1010, 16'd0, 8'd2},
        {4'b1010, 16'd2, 8'd4}, {4'b0110, 16'd2, 8'd4},
        {4'b1111, 16'd1, 8'd3}, {4'b0000, 16'd3, 8'd5},
        {4'b1001, 16'd0, 8'd2}, {4'b0110, 16'd6, 8'd9}};

    task automatic chk(string req, string what, logic [NCH-1:0] act, logic [NCH-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic chk_int(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_edge();
        if (!rst_n) begin
            m_slot = 0; m_dt = '0; m_hi = '0; m_lo = '0;
            for (int k = 0; k < NCH; k++) begin m_last[k] = 1'b0; m_cnt[k] = '1; end
        end else begin
            int s;
            logic g;
            logic [CW-1:0] c;
            s = m_slot;
            g = gate_cmd[s];
            if (g != m_last[s])   c = '0;
            else if (&m_cnt[s])   c = m_cnt[s];
            else                  c = m_cnt[s] + 1'b1;
            m_last[s] = g;
            m_cnt[s]  = c;
            m_hi[s]   = g & (c >= m_dt);
            m_lo[s]   = ~g & (c >= m_dt);
            if (s == NCH - 1) m_dt = blank_frames;
            m_slot = (s + 1) % NCH;
        end
    endtask

    // one clock: model at the edge, compare at the falling edge
    task automatic cyc(string req);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(req, "hi_gate", hi_gate, m_hi);
        chk(req, "lo_gate", lo_gate, m_lo);
        chk("R3", "overlap", hi_gate & lo_gate, '0);
    endtask

    task automatic to_slot(int k);
        while (m_slot != k) cyc("R8");
    endtask

    task automatic finish_run();
        if (!reported) begin
            reported = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int d;
        int n;
        int lo_at;
        int hi_at;
        bit seen;

        // R1: reset state
        repeat (3) cyc("R1");
        chk("R1", "hi after reset", hi_gate, '0);
        chk("R1", "lo after reset", lo_gate, '0);

        // R8: slot order after release
        rst_n = 1'b1;
        cyc("R8"); chk("R8", "lo slot0", lo_gate, 4'b0001);
        cyc("R8"); chk("R8", "lo slot1", lo_gate, 4'b0011);
        cyc("R8"); cyc("R8"); chk("R8", "lo frame", lo_gate, 4'b1111);

        // table walk, R2 with R4 on zero settings
        for (int i = 0; i < 8; i++) begin
            gate_cmd     = VEC[i][27:24];
            blank_frames = VEC[i][23:8];
            for (int c = 0; c < int'(VEC[i][7:0]) * NCH; c++) cyc("R2");
            if (VEC[i][23:8] == 16'd0 && VEC[i][7:0] >= 8'd2) begin
                chk("R4", "hi equals command", hi_gate, gate_cmd);
                chk("R4", "lo equals inverse", lo_gate, ~gate_cmd);
            end
        end

        // R5: rising edge distance, setting 3
        blank_frames = 16'd3; gate_cmd = '0;
        repeat (6 * NCH) cyc("R2");
        gate_cmd[2] = 1'b1;
        d = ((2 - m_slot + NCH) % NCH) + 1;
        n = 0; lo_at = 0; hi_at = 0;
        while (n < 40 && hi_at == 0) begin
            cyc("R5"); n++;
            if (lo_gate[2] == 1'b0 && lo_at == 0) lo_at = n;
            if (hi_gate[2] == 1'b1) hi_at = n;
        end
        chk_int("R5", "lo fall edge", lo_at, d);
        chk_int("R5", "hi rise edge", hi_at, d + 3 * NCH);

        // R6: falling edge distance
        repeat (3) cyc("R2");
        gate_cmd[2] = 1'b0;
        d = ((2 - m_slot + NCH) % NCH) + 1;
        n = 0; lo_at = 0; hi_at = 0;
        while (n < 40 && lo_at == 0) begin
            cyc("R6"); n++;
            if (hi_gate[2] == 1'b0 && hi_at == 0) hi_at = n;
            if (lo_gate[2] == 1'b1) lo_at = n;
        end
        chk_int("R6", "hi fall edge", hi_at, d);
        chk_int("R6", "lo rise edge", lo_at, d + 3 * NCH);

        // R7: mid-frame change waits for the frame boundary
        blank_frames = 16'd4; gate_cmd = '0;
        repeat (6 * NCH) cyc("R2");
        to_slot(0);
        gate_cmd = 4'b1111;
        repeat (2 * NCH) cyc("R7");
        cyc("R7");
        blank_frames = 16'd2;
        repeat (NCH - 1) cyc("R7");
        chk("R7", "old setting holds in frame", hi_gate, 4'b0000);
        repeat (NCH) cyc("R7");
        chk("R7", "new setting next frame", hi_gate, 4'b1111);

        // R9: saturated counts meet the largest setting
        blank_frames = 16'hFFFF; gate_cmd = '0; rst_n = 1'b0;
        repeat (2) cyc("R1");
        rst_n = 1'b1;
        repeat (3 * NCH) cyc("R9");
        chk("R9", "lo with max setting", lo_gate, 4'b1111);
        chk("R9", "hi with max setting", hi_gate, 4'b0000);

        // R10: pulse shorter than the setting
        blank_frames = 16'd3;
        repeat (2 * NCH) cyc("R2");
        to_slot(0);
        gate_cmd[1] = 1'b1;
        seen = 1'b0;
        for (int c = 0; c < 2 * NCH; c++) begin
            cyc("R10");
            if (hi_gate[1]) seen = 1'b1;
        end
        gate_cmd[1] = 1'b0;
        for (int c = 0; c < 2 * NCH; c++) begin
            cyc("R10");
            if (hi_gate[1]) seen = 1'b1;
        end
        chk_int("R10", "upper raised by short pulse", int'(seen), 0);
        chk("R10", "lo still blanked", lo_gate, 4'b1101);
        repeat (2 * NCH) cyc("R10");
        chk("R10", "lo restored", lo_gate, 4'b1111);

        finish_run();
    end
endmodule